// File: doc/BRIEF.md
# Programmable Clock-Output Divider Bank

This block models a bank of clock outputs, each derived from a common input clock through its own programmable divider. Every output channel has three configuration bytes. A divider byte holds separate high-phase and low-phase cycle counts. A control byte holds a bypass bit that passes the input clock straight through for divide-by-1. A drive byte switches the output on or off and, on the last channels, can also turn on an inverted companion output. A byte-wide register port writes and reads this configuration in the same clock domain.

Every configuration write lands in a pending (shadow) copy, and reads return that pending copy. Nothing reaches the outputs until software writes the update register. That write sets a flag. The flag copies every pending value into the active set together on the next edge, then clears itself. A sync bit in its own register freezes every running divider low while it is active. Committing the bit high and then low restarts all dividers in phase.

Each divider is a small state machine with three states. `DV_IDLE` holds the output low and the count at zero. `DV_HIGH` drives the output high. `DV_LOW` drives it low. The transitions are as follows:
- `DV_IDLE` moves to `DV_HIGH` when the channel is allowed to run.
- `DV_HIGH` moves to `DV_LOW` once the count reaches the high count.
- `DV_LOW` moves back to `DV_HIGH` once the count reaches the low count.
- Either running state returns to `DV_IDLE` when the run permission drops. This happens on sync, power-down or bypass.

Top module: `clkdiv_bank`

## Requirements
- R1: After reset every pending and active register reads 0x00 and every output is on. Each divider runs at divide-by-2: one input cycle high, then one low, starting high on the first edge after reset.
- R2: Address 0x00 always reads 0x10, and writes to it have no effect.
- R3: A write to a divider, control, drive or sync register changes only the pending copy, which reads back at once. The outputs keep their old behaviour until an update.
- R4: Writing a value with bit 0 set to address 0x5A sets an update flag that reads back as 0x01 in the following cycle. The flag copies all pending values into the active set on the next edge and then reads 0x00. Writing 0x00 there commits nothing.
- R5: The divider byte for channel i sits at 0x4A+2i, with bits [3:0] as the high count H and bits [7:4] as the low count L. The output is high for H+1 input cycles, then low for L+1 cycles, repeating.
- R6: Bit 7 of the control byte at 0x4B+2i bypasses the divider, and the output then follows the input clock (divide-by-1).
- R7: While bit 2 of register 0x58 is active, every output is held low. Once it is committed back to 0, all running channels start their high phase on the same input edge.
- R8: On channels 0 to 2 (drive bytes 0x3D to 0x3F), the output is on only when bits [1:0] are 00. Any other value holds the output at 0.
- R9: On channels 3 and 4 (drive bytes 0x40, 0x41), bit 0 = 1 holds the output at 0. The inverted output equals the complement of the output only when the channel is on with bit 3 (CMOS) and bit 4 both set. Otherwise it drives 0.
- R10: Addresses outside the map read 0x00, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock; also clocks the register port |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Write strobe, sampled on the rising edge |
| reg_addr | input | 8 | Register address for read and write |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr (pending copy), combinational |
| clk_out | output | NUM_CH | Divided clock outputs |
| clk_out_n | output | NUM_CH | Inverted companion outputs (channels PD_CH and up) |

## Verification
The bench builds the block with its defaults: five channels, three of them using the two-bit power-down field, and 4-bit cycle counts. This covers both output-stage variants, the inverted companion output, and asymmetric ratios. It also covers the full set of channels that must restart together after a sync. Waveforms are captured one sample per input cycle just after the rising edge, and the phase lengths and rise positions are measured from those samples. Bypass is checked at both clock levels.

// File: rtl/clkdiv_pkg.sv
`timescale 1ns/1ps
package clkdiv_pkg;
    localparam logic [7:0] ADDR_ID   = 8'h00;
    localparam logic [7:0] ID_VALUE  = 8'h10;
    localparam logic [7:0] ADDR_SYNC = 8'h58;
    localparam logic [7:0] ADDR_UPD  = 8'h5A;
    localparam logic [7:0] DIV_BASE  = 8'h4A;
    localparam logic [7:0] CTL_BASE  = 8'h4B;
    localparam logic [7:0] DRV_BASE  = 8'h3D;
    localparam int         SYNC_BIT  = 2;
    localparam int         BYP_BIT   = 7;

    typedef enum logic [1:0] {
        DV_IDLE = 2'd0,
        DV_HIGH = 2'd1,
        DV_LOW  = 2'd2
    } dv_state_t;
endpackage

// File: rtl/clkdiv_regs.sv
`timescale 1ns/1ps
module clkdiv_regs
    import clkdiv_pkg::*;
#(
    parameter int NUM_CH = 5,
    parameter int PD_CH  = 3,
    parameter int CNT_W  = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr,
    input  logic [7:0]              addr,
    input  logic [7:0]              wdata,
    output logic [7:0]              rdata,
    output logic                    upd_q,
    output logic [NUM_CH*CNT_W-1:0] act_hi,
    output logic [NUM_CH*CNT_W-1:0] act_lo,
    output logic [NUM_CH-1:0]       act_byp,
    output logic [NUM_CH-1:0]       act_on,
    output logic [NUM_CH-1:0]       act_inv,
    output logic                    act_sync
);
    logic [7:0] sh_div [NUM_CH];
    logic [7:0] sh_ctl [NUM_CH];
    logic [7:0] sh_drv [NUM_CH];
    logic [7:0] sh_sync;

    // update flag: set by write, consumed on the next edge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            upd_q    <= 1'b0;
            sh_sync  <= 8'h00;
            act_sync <= 1'b0;
        end else begin
            upd_q <= wr && (addr == ADDR_UPD) && wdata[0];
            if (wr && addr == ADDR_SYNC) sh_sync <= wdata;
            if (upd_q) act_sync <= sh_sync[SYNC_BIT];
        end
    end

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        localparam logic [7:0] A_DIV = DIV_BASE + 8'(2*g);
        localparam logic [7:0] A_CTL = CTL_BASE + 8'(2*g);
        localparam logic [7:0] A_DRV = DRV_BASE + 8'(g);

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                sh_div[g] <= 8'h00;
                sh_ctl[g] <= 8'h00;
                sh_drv[g] <= 8'h00;
            end else if (wr) begin
                if (addr == A_DIV) sh_div[g] <= wdata;
                if (addr == A_CTL) sh_ctl[g] <= wdata;
                if (addr == A_DRV) sh_drv[g] <= wdata;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                act_hi[g*CNT_W +: CNT_W] <= '0;
                act_lo[g*CNT_W +: CNT_W] <= '0;
                act_byp[g]               <= 1'b0;
            end else if (upd_q) begin
                act_hi[g*CNT_W +: CNT_W] <= sh_div[g][CNT_W-1:0];
                act_lo[g*CNT_W +: CNT_W] <= sh_div[g][2*CNT_W-1:CNT_W];
                act_byp[g]               <= sh_ctl[g][BYP_BIT];
            end
        end

        if (g < PD_CH) begin : g_pd
            // two-bit power-down field, on only when zero
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) act_on[g] <= 1'b1;
                else if (upd_q) act_on[g] <= (sh_drv[g][1:0] == 2'b00);
            end
            assign act_inv[g] = 1'b0;
        end else begin : g_lg
            // off bit plus CMOS / inverted-output enables
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    act_on[g]  <= 1'b1;
                    act_inv[g] <= 1'b0;
                end else if (upd_q) begin
                    act_on[g]  <= !sh_drv[g][0];
                    act_inv[g] <= sh_drv[g][3] && sh_drv[g][4];
                end
            end
        end
    end

    always_comb begin
        rdata = 8'h00;
        if (addr == ADDR_ID)   rdata = ID_VALUE;
        if (addr == ADDR_SYNC) rdata = sh_sync;
        if (addr == ADDR_UPD)  rdata = {7'b0, upd_q};
        for (int i = 0; i < NUM_CH; i++) begin
            if (addr == DIV_BASE + 8'(2*i)) rdata = sh_div[i];
            if (addr == CTL_BASE + 8'(2*i)) rdata = sh_ctl[i];
            if (addr == DRV_BASE + 8'(i))   rdata = sh_drv[i];
        end
    end
endmodule

// File: rtl/clkdiv_chan.sv
`timescale 1ns/1ps
module clkdiv_chan
    import clkdiv_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [CNT_W-1:0] hi,
    input  logic [CNT_W-1:0] lo,
    output logic             ph_hi
);
    dv_state_t        state, state_nx;
    logic [CNT_W-1:0] cnt, cnt_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= DV_IDLE;
            cnt   <= '0;
        end else begin
            state <= state_nx;
            cnt   <= cnt_nx;
        end
    end

    always_comb begin
        state_nx = state;
        cnt_nx   = cnt + 1'b1;
        unique case (state)
            DV_IDLE: begin
                cnt_nx = '0;
                if (run) state_nx = DV_HIGH;
            end
            DV_HIGH: begin
                if (!run) begin
                    state_nx = DV_IDLE;
                    cnt_nx   = '0;
                end else if (cnt >= hi) begin
                    state_nx = DV_LOW;
                    cnt_nx   = '0;
                end
            end
            DV_LOW: begin
                if (!run) begin
                    state_nx = DV_IDLE;
                    cnt_nx   = '0;
                end else if (cnt >= lo) begin
                    state_nx = DV_HIGH;
                    cnt_nx   = '0;
                end
            end
            default: begin
                state_nx = DV_IDLE;
                cnt_nx   = '0;
            end
        endcase
    end

    always_comb begin
        ph_hi = (state == DV_HIGH);
    end
endmodule

// File: rtl/clkdiv_bank.sv
`timescale 1ns/1ps
module clkdiv_bank #(
    parameter int NUM_CH = 5,
    parameter int PD_CH  = 3,
    parameter int CNT_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [7:0]        reg_addr,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    output logic [NUM_CH-1:0] clk_out,
    output logic [NUM_CH-1:0] clk_out_n
);
    logic                    upd_q;
    logic                    act_sync;
    logic [NUM_CH*CNT_W-1:0] act_hi, act_lo;
    logic [NUM_CH-1:0]       act_byp, act_on, act_inv;
    logic [NUM_CH-1:0]       ph_hi, src;

    clkdiv_regs #(.NUM_CH(NUM_CH), .PD_CH(PD_CH), .CNT_W(CNT_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (reg_wr),
        .addr     (reg_addr),
        .wdata    (reg_wdata),
        .rdata    (reg_rdata),
        .upd_q    (upd_q),
        .act_hi   (act_hi),
        .act_lo   (act_lo),
        .act_byp  (act_byp),
        .act_on   (act_on),
        .act_inv  (act_inv),
        .act_sync (act_sync)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_out
        clkdiv_chan #(.CNT_W(CNT_W)) u_chan (
            .clk   (clk),
            .rst_n (rst_n),
            .run   (act_on[g] & ~act_sync & ~act_byp[g]),
            .hi    (act_hi[g*CNT_W +: CNT_W]),
            .lo    (act_lo[g*CNT_W +: CNT_W]),
            .ph_hi (ph_hi[g])
        );
        assign src[g]       = act_byp[g] ? clk : ph_hi[g];
        assign clk_out[g]   = act_on[g] & ~act_sync & src[g];
        assign clk_out_n[g] = act_on[g] & ~act_sync & act_inv[g] & ~src[g];
    end
endmodule

// File: rtl/clkdiv_bank_chk.sv
`timescale 1ns/1ps
module clkdiv_bank_chk #(
    parameter int NUM_CH = 5,
    parameter int CNT_W  = 4
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    reg_wr,
    input logic [7:0]              reg_addr,
    input logic                    upd_bit,
    input logic [7:0]              reg_rdata,
    input logic                    upd_q,
    input logic                    act_sync,
    input logic                    act_on0,
    input logic [NUM_CH-1:0]       clk_out,
    input logic [NUM_CH-1:0]       clk_out_n,
    input logic [NUM_CH*CNT_W-1:0] act_hi,
    input logic [NUM_CH*CNT_W-1:0] act_lo
);
    assert_id_const_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == 8'h00) |-> (reg_rdata == 8'h10));

    assert_hold_pending_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_q |=> ($stable(act_hi) && $stable(act_lo)));

    assert_upd_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == 8'h5A && upd_bit) |=> upd_q);

    assert_upd_selfclear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        upd_q |=> !upd_q);

    assert_sync_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (act_sync && $past(act_sync)) |-> (clk_out == '0));

    assert_pd_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !act_on0 |-> !clk_out[0]);

    assert_inv_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_out & clk_out_n) == '0);
endmodule

bind clkdiv_bank clkdiv_bank_chk #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .upd_bit   (reg_wdata[0]),
    .reg_rdata (reg_rdata),
    .upd_q     (upd_q),
    .act_sync  (act_sync),
    .act_on0   (act_on[0]),
    .clk_out   (clk_out),
    .clk_out_n (clk_out_n),
    .act_hi    (act_hi),
    .act_lo    (act_lo)
);

// File: tb/clkdiv_bank_test.sv
`timescale 1ns/1ps
module clkdiv_bank_test;
    localparam int NCH = 5;
    localparam int NS  = 64;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           reg_wr = 1'b0;
    logic [7:0]     reg_addr = 8'h00;
    logic [7:0]     reg_wdata = 8'h00;
    logic [7:0]     reg_rdata;
    logic [NCH-1:0] clk_out, clk_out_n;

    int n_chk = 0;
    int n_fail = 0;
    logic [NCH-1:0] smp  [NS];
    logic [NCH-1:0] smpn [NS];

    always #2.5 clk = ~clk;

    clkdiv_bank #(.NUM_CH(NCH), .PD_CH(3), .CNT_W(4)) uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .clk_out(clk_out), .clk_out_n(clk_out_n)
    );

    // {req, is_write, addr, data-or-expected}
    localparam logic [31:0] VEC [13] = '{
        32'h02_00_00_10,  // R2 identification value
        32'h01_00_4A_00,  // R1 divider reset
        32'h01_00_53_00,  // R1 control reset
        32'h01_00_3D_00,  // R1 drive reset
        32'h02_01_00_55,  // R2 write to id
        32'h02_00_00_10,  // R2 id unchanged
        32'h03_01_4C_A5,  // R3 pending write
        32'h03_00_4C_A5,  // R3 pending readback
        32'h0A_01_60_FF,  // R10 unmapped write
        32'h0A_00_60_00,  // R10 unmapped read
        32'h0A_00_3C_00,  // R10 just below map
        32'h03_01_4C_00,  // R3 restore
        32'h03_00_4C_00   // R3 restored
    };

    task automatic check(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] v);
        @(negedge clk);
        reg_addr = a;
        #1 v = reg_rdata;
    endtask

    task automatic commit();
        wr(8'h5A, 8'h01);
    endtask

    task automatic capture();
        for (int k = 0; k < NS; k++) begin
            @(posedge clk);
            #1;
            smp[k]  = clk_out;
            smpn[k] = clk_out_n;
        end
    endtask

    function automatic int rise_at(input int ch);
        for (int k = 1; k < NS; k++)
            if (!smp[k-1][ch] && smp[k][ch]) return k;
        return -1;
    endfunction

    function automatic int run_len(input int ch, input int from, input logic lvl);
        int n = 0;
        for (int k = from; k < NS; k++) begin
            if (smp[k][ch] != lvl) return n;
            n++;
        end
        return n;
    endfunction

    function automatic int ones(input int ch, input logic inv);
        int n = 0;
        for (int k = 0; k < NS; k++) n += inv ? int'(smpn[k][ch]) : int'(smp[k][ch]);
        return n;
    endfunction

    task automatic check_wave(input string req, input int ch, input int eh, input int el);
        int r, h, l;
        r = rise_at(ch);
        if (r < 0) r = 0;
        h = run_len(ch, r, 1'b1);
        l = run_len(ch, r + h, 1'b0);
        check(req, $sformatf("ch%0d high cycles", ch), h, eh);
        check(req, $sformatf("ch%0d low cycles", ch), l, el);
    endtask

    initial begin
        #1000000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] v;
        int r0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset waveform, all channels divide-by-2 starting high
        capture();
        check("R1", "ch0 first sample", int'(smp[0][0]), 1);
        check_wave("R1", 0, 1, 1);
        check_wave("R1", 4, 1, 1);
        check("R9", "inverted outputs after reset", ones(3, 1'b1) + ones(4, 1'b1), 0);

        // register table
        foreach (VEC[i]) begin
            if (VEC[i][23:16] != 8'h00) wr(VEC[i][15:8], VEC[i][7:0]);
            else begin
                rd(VEC[i][15:8], v);
                check($sformatf("R%0d", VEC[i][31:24]), $sformatf("read 0x%02h", VEC[i][15:8]),
                      int'(v), int'(VEC[i][7:0]));
            end
        end

        // R3: pending divider writes do not reach outputs
        wr(8'h4A, 8'h22);
        wr(8'h4C, 8'h31);
        rd(8'h4A, v);
        check("R3", "pending readback 0x4A", int'(v), 8'h22);
        capture();
        check_wave("R3", 0, 1, 1);

        // R4: writing 0 to the update register commits nothing
        wr(8'h5A, 8'h00);
        capture();
        check_wave("R4", 0, 1, 1);

        // R4: update flag visible for exactly one cycle
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 8'h5A; reg_wdata = 8'h01;
        @(negedge clk);
        reg_wr = 1'b0;
        #1 check("R4", "update flag next cycle", int'(reg_rdata), 1);
        @(negedge clk);
        #1 check("R4", "update flag cleared", int'(reg_rdata), 0);

        // R7: sync held, then released
        wr(8'h58, 8'h04);
        commit();
        repeat (2) @(negedge clk);
        capture();
        check("R7", "outputs during sync", ones(0,1'b0)+ones(1,1'b0)+ones(2,1'b0)+ones(3,1'b0)+ones(4,1'b0), 0);
        rd(8'h58, v);
        check("R7", "sync readback", int'(v), 8'h04);
        wr(8'h58, 8'h00);
        commit();
        capture();
        // R5: asymmetric and symmetric ratios
        check_wave("R5", 0, 3, 3);
        check_wave("R5", 1, 2, 4);
        check_wave("R5", 2, 1, 1);
        r0 = rise_at(0);
        check("R7", "ch0 rise sample", r0, 1);
        for (int c = 1; c < NCH; c++)
            check("R7", $sformatf("ch%0d aligned rise", c), rise_at(c), r0);

        // R6: bypass on ch2 follows input clock
        wr(8'h4F, 8'h80);
        commit();
        repeat (2) @(negedge clk);
        for (int k = 0; k < 3; k++) begin
            @(posedge clk); #1 check("R6", "bypass high level", int'(clk_out[2]), 1);
            @(negedge clk); #1 check("R6", "bypass low level", int'(clk_out[2]), 0);
        end

        // R8: power-down codes on ch0
        wr(8'h3D, 8'h02);
        commit();
        capture();
        check("R8", "ch0 off with code 2", ones(0, 1'b0), 0);
        wr(8'h3D, 8'h01);
        commit();
        capture();
        check("R8", "ch0 off with code 1", ones(0, 1'b0), 0);
        check_wave("R8", 1, 2, 4);

        // R9: ch3 off, ch4 CMOS with inverted output
        wr(8'h40, 8'h01);
        wr(8'h41, 8'h18);
        commit();
        capture();
        check("R9", "ch3 off", ones(3, 1'b0) + ones(3, 1'b1), 0);
        check("R9", "ch4 inverted toggles", int'(ones(4, 1'b1) > 0), 1);
        begin
            int mism = 0;
            for (int k = 0; k < NS; k++) if (smpn[k][4] == smp[k][4]) mism++;
            check("R9", "ch4 inverted is complement", mism, 0);
        end
        wr(8'h40, 8'h10);
        commit();
        capture();
        check("R9", "ch3 running", int'(ones(3, 1'b0) > 0), 1);
        check("R9", "ch3 inverted needs CMOS bit", ones(3, 1'b1), 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule